// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a processor port that reads and writes 32-bit words and a plain memory port. Every processor address is split into three fields: a block offset in the low bits, a set index above it, and a tag in the rest. Each set holds one 8-byte block, a tag and a valid bit. The default size is 16 KiB, which gives 2048 sets. Addresses are taken as physical.

A read that hits is answered from the data array without touching memory. A read that misses fetches the whole block from memory and refills the set, so a set always holds the block it last received. It then returns the requested word. Every write goes through to memory as a single word write. A write that hits also updates the cached word. A write that misses leaves the set as it was, so the cache does not allocate on writes. Two addresses whose distance is a multiple of the capacity share a set and evict each other.

Both ports use valid/ready handshakes. A processor request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. The cache then accepts nothing more until the matching response has been taken. A response stays valid, with its data and hit flag unchanged, until `cpu_rsp_ready` is high. Memory requests follow the same holding rule toward `mem_req_ready`. Memory answers each accepted request with one cycle of `mem_rsp_valid`, which carries the block for a read and serves as the acknowledge for a write. Memory cannot stall its response.

Top module: `dm_wt_cache`

## Requirements
- R1: The address fields are: byte offset in bits [2:0], set index in bits [13:3], tag in bits [31:14]. Bit 2 selects the word within the block: 0 is the low half of the block and 1 is the high half. Bits [1:0] are ignored. A block read goes to the address with bits [2:0] cleared.
- R2: After reset no set is valid, so the first read of any address returns `cpu_rsp_hit`=0 and issues a memory read.
- R3: A read miss issues exactly one memory block read and writes the returned block into the set. It then answers with the word picked by bit 2 from `mem_rsp_data` (bits [31:0] or [63:32]), with `cpu_rsp_hit`=0.
- R4: A read of a block already resident, including the other word of that block, answers with `cpu_rsp_hit`=1 and the cached word, and makes no memory request.
- R5: A read miss to an address 16384 bytes (or a multiple of that) away from the resident block replaces it. A later read of the first address misses again.
- R6: Every write issues exactly one memory word write carrying the request's word-aligned address and data. The write's response appears only after memory has acknowledged.
- R7: A write that hits updates the cached word, reports `cpu_rsp_hit`=1, and a following read of that word hits and returns the new data.
- R8: A write that misses reports `cpu_rsp_hit`=0 and leaves the set unchanged: the block already resident there still hits, and a later read of the written address misses and returns the written data from memory.
- R9: `cpu_req_ready` is high only while no request is in progress. A response is held stable until `cpu_rsp_ready`. A memory request is held with stable fields until `mem_req_ready`.
- R10: For sequential and strided read sequences, the hit flag of every read matches a direct-mapped reference model of the same geometry, and so do the total hit counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | 32 | Read data (meaningful for reads) |
| cpu_rsp_hit | output | 1 | 1 when the access found its block resident |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = word write, 0 = block read |
| mem_req_addr | output | 32 | Block-aligned for reads, word-aligned for writes |
| mem_req_wdata | output | 32 | Word to write |
| mem_rsp_valid | input | 1 | Block data or write acknowledge |
| mem_rsp_data | input | 64 | Block returned for a read |

## Verification
The assertions take for granted that memory sends exactly one `mem_rsp_valid` pulse for each accepted request, and only after accepting it. They also assume the processor does not care about `cpu_rsp_rdata` on writes. The bench's memory model raises `mem_req_ready` only after a request has been stable for a cycle. It answers two cycles after acceptance and never otherwise. The processor driver keeps at most one request in progress. It holds back `cpu_rsp_ready` only in the scenario that tests response holding.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEMREQ,
    ST_MEMWAIT,
    ST_RESP
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int UPPER_W = 30,
  parameter int WSEL_W  = 1,
  parameter int IDX_W   = 11,
  parameter int TAG_W   = 18
) (
  input  logic [UPPER_W-1:0] addr_upper,
  output logic [TAG_W-1:0]   tag,
  output logic [IDX_W-1:0]   idx,
  output logic [WSEL_W-1:0]  wsel
);
  assign wsel = addr_upper[WSEL_W-1:0];
  assign idx  = addr_upper[WSEL_W +: IDX_W];
  assign tag  = addr_upper[UPPER_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int SETS  = 2048,
  parameter int IDX_W = 11,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int SETS   = 2048,
  parameter int IDX_W  = 11,
  parameter int WPB    = 2,
  parameter int WSEL_W = 1,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [WPB-1:0][WORD_W-1:0]    rd_block,
  input  logic                          fill_en,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [WPB-1:0][WORD_W-1:0]    fill_block,
  input  logic                          word_en,
  input  logic [IDX_W-1:0]              word_idx,
  input  logic [WSEL_W-1:0]             word_sel,
  input  logic [WORD_W-1:0]             word_data
);
  logic [WPB-1:0][WORD_W-1:0] blk_mem [SETS];

  always_ff @(posedge clk) begin
    if (fill_en) blk_mem[fill_idx] <= fill_block;
    else if (word_en) blk_mem[word_idx][word_sel] <= word_data;
  end

  assign rd_block = blk_mem[rd_idx];
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int CAP_BYTES = 16384,
  parameter int BLK_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_we,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [WORD_W-1:0]       cpu_req_wdata,
  output logic                    cpu_rsp_valid,
  input  logic                    cpu_rsp_ready,
  output logic [WORD_W-1:0]       cpu_rsp_rdata,
  output logic                    cpu_rsp_hit,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_we,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [WORD_W-1:0]       mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [BLK_BYTES*8-1:0]  mem_rsp_data
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int SETS       = CAP_BYTES / BLK_BYTES;
  localparam int WPB        = BLK_BYTES / WORD_BYTES;
  localparam int LSB_W      = $clog2(WORD_BYTES);
  localparam int OFF_W      = $clog2(BLK_BYTES);
  localparam int WSEL_W     = OFF_W - LSB_W;
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int UPPER_W    = ADDR_W - LSB_W;

  dmc_state_e               state_q, state_d;
  logic                     we_q;
  logic [UPPER_W-1:0]       addr_q;
  logic [WORD_W-1:0]        wdata_q;
  logic                     hit_q;
  logic [WORD_W-1:0]        rdata_q;

  logic [TAG_W-1:0]         a_tag;
  logic [IDX_W-1:0]         a_idx;
  logic [WSEL_W-1:0]        a_wsel;
  logic                     ts_valid;
  logic [TAG_W-1:0]         ts_tag;
  logic [WPB-1:0][WORD_W-1:0] ds_block;
  logic [WPB-1:0][WORD_W-1:0] fill_block;
  logic                     lookup_hit;
  logic                     fill_now;
  logic                     wr_hit_now;

  dmc_addr_split #(
    .UPPER_W(UPPER_W), .WSEL_W(WSEL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_split (
    .addr_upper(addr_q), .tag(a_tag), .idx(a_idx), .wsel(a_wsel)
  );

  dmc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(a_idx), .rd_valid(ts_valid), .rd_tag(ts_tag),
    .wr_en(fill_now), .wr_idx(a_idx), .wr_tag(a_tag)
  );

  assign fill_block = mem_rsp_data;

  dmc_data_store #(
    .SETS(SETS), .IDX_W(IDX_W), .WPB(WPB), .WSEL_W(WSEL_W), .WORD_W(WORD_W)
  ) u_data (
    .clk(clk),
    .rd_idx(a_idx), .rd_block(ds_block),
    .fill_en(fill_now), .fill_idx(a_idx), .fill_block(fill_block),
    .word_en(wr_hit_now), .word_idx(a_idx), .word_sel(a_wsel), .word_data(wdata_q)
  );

  assign lookup_hit = ts_valid && (ts_tag == a_tag);
  assign fill_now   = (state_q == ST_MEMWAIT) && mem_rsp_valid && !we_q;
  assign wr_hit_now = (state_q == ST_LOOKUP) && we_q && lookup_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cpu_req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP:  state_d = (!we_q && lookup_hit) ? ST_RESP : ST_MEMREQ;
      ST_MEMREQ:  if (mem_req_ready) state_d = ST_MEMWAIT;
      ST_MEMWAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:    if (cpu_rsp_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req_valid) begin
        we_q    <= cpu_req_we;
        addr_q  <= cpu_req_addr[ADDR_W-1:LSB_W];
        wdata_q <= cpu_req_wdata;
      end
      if (state_q == ST_LOOKUP) begin
        hit_q <= lookup_hit;
        if (!we_q && lookup_hit) rdata_q <= ds_block[a_wsel];
      end
      if (fill_now) rdata_q <= fill_block[a_wsel];
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_rdata = rdata_q;
  assign cpu_rsp_hit   = hit_q;

  assign mem_req_valid = (state_q == ST_MEMREQ);
  assign mem_req_we    = we_q;
  assign mem_req_wdata = wdata_q;
  assign mem_req_addr  = we_q ? {addr_q, {LSB_W{1'b0}}}
                              : {addr_q[UPPER_W-1:WSEL_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int BLK_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_we,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [WORD_W-1:0] cpu_rsp_rdata,
  input logic              cpu_rsp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0] mem_req_wdata
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int LSB_W = $clog2(WORD_W / 8);

  logic c_we;
  logic c_mem_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_we       <= 1'b0;
      c_mem_seen <= 1'b0;
    end else if (cpu_req_valid && cpu_req_ready) begin
      c_we       <= cpu_req_we;
      c_mem_seen <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      c_mem_seen <= 1'b1;
    end
  end

  a_r1_rd_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> mem_req_addr[OFF_W-1:0] == '0);

  a_r1_wr_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_addr[LSB_W-1:0] == '0);

  a_r4_hit_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cpu_rsp_hit && !c_we |-> !c_mem_seen);

  a_r6_write_reaches_memory: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && c_we |-> c_mem_seen);

  a_r9_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  a_r9_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)
      && $stable(cpu_rsp_hit));

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);
endmodule

bind dm_wt_cache dm_wt_cache_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLK_BYTES(BLK_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_we(cpu_req_we),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
  .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_hit(cpu_rsp_hit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/dm_wt_cache_tb.sv
module dm_wt_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 16384;
  localparam int NSETS      = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_ready, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_rsp_valid, cpu_rsp_ready = 1'b1, cpu_rsp_hit;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  int checks = 0, failures = 0;
  int mem_rd_cnt = 0, mem_wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic [31:0] mem_m [logic [31:0]];
  bit          ref_valid [NSETS];
  logic [17:0] ref_tag [NSETS];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wt_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_hit(cpu_rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] wa = {a[31:2], 2'b00};
    if (mem_m.exists(wa)) return mem_m[wa];
    return wa ^ 32'hC0DE_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: ready one cycle after request appears, response two cycles later
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic        we;
        logic [31:0] a, d;
        @(negedge clk);
        we = mem_req_we; a = mem_req_addr; d = mem_req_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (we) begin
          mem_m[a] = d; mem_wr_cnt++; last_wr_addr = a; last_wr_data = d;
          mem_rsp_data = '0;
        end else begin
          mem_rd_cnt++; last_rd_addr = a;
          mem_rsp_data = {mem_word(a + 32'd4), mem_word(a)};
        end
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // reference direct-mapped model: returns expected hit, updates on read miss
  function automatic bit ref_access(input bit we, input logic [31:0] a);
    int  s   = int'(a[13:3]);
    bit  h   = ref_valid[s] && ref_tag[s] == a[31:14];
    if (!we && !h) begin
      ref_valid[s] = 1; ref_tag[s] = a[31:14];
    end
    return h;
  endfunction

  task automatic do_access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                           input int hold, output logic [31:0] rd, output logic hit);
    @(negedge clk);
    cpu_rsp_ready = (hold == 0);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_rdata; hit = cpu_rsp_hit;
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        check(cpu_rsp_valid && cpu_rsp_rdata == rd && cpu_rsp_hit == hit,
              "R9 response held", cpu_rsp_rdata, rd);
      end
      cpu_rsp_ready = 1'b1;
    end
  endtask

  // read with data and model-hit check
  task automatic rd_chk(input logic [31:0] a, input string req, output logic hit);
    logic [31:0] rd;
    bit exp_h = ref_access(0, a);
    do_access(0, a, '0, 0, rd, hit);
    check(hit == exp_h, {req, " hit flag"}, {31'd0, hit}, {31'd0, exp_h});
    check(rd == mem_word(a), {req, " read data"}, rd, mem_word(a));
  endtask

  task automatic wr_chk(input logic [31:0] a, input logic [31:0] d, input string req,
                        output logic hit);
    logic [31:0] rd;
    int  w0 = mem_wr_cnt;
    bit  exp_h = ref_access(1, a);
    do_access(1, a, d, 0, rd, hit);
    check(hit == exp_h, {req, " write hit flag"}, {31'd0, hit}, {31'd0, exp_h});
    check(mem_wr_cnt == w0 + 1 && last_wr_addr == {a[31:2], 2'b00} && last_wr_data == d,
          "R6 one memory write with address and data", last_wr_data, d);
  endtask

  task automatic t_reset();
    check(cpu_req_ready == 1'b1 && cpu_rsp_valid == 1'b0 && mem_req_valid == 1'b0,
          "R9 reset idle", {29'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 32'h4);
  endtask

  task automatic t_cold_miss_and_split();
    logic h;
    int r0 = mem_rd_cnt;
    rd_chk(32'h0000_2007, "R2 R3", h);
    check(h == 1'b0, "R2 first access misses", {31'd0, h}, 32'd0);
    check(mem_rd_cnt == r0 + 1, "R3 one block read", mem_rd_cnt, r0 + 1);
    check(last_rd_addr == 32'h0000_2000, "R1 block-aligned read address",
          last_rd_addr, 32'h0000_2000);
  endtask

  task automatic t_read_hit();
    logic h;
    int r0 = mem_rd_cnt;
    rd_chk(32'h0000_2001, "R4 same word", h);
    rd_chk(32'h0000_2004, "R4 other word", h);
    check(h == 1'b1 && mem_rd_cnt == r0, "R4 hit without memory read", mem_rd_cnt, r0);
  endtask

  task automatic t_conflict();
    logic h;
    rd_chk(32'h0000_3010, "R5 first", h);
    rd_chk(32'h0000_3010 + CAP, "R5 conflicting", h);
    check(h == 1'b0, "R5 conflict misses", {31'd0, h}, 32'd0);
    rd_chk(32'h0000_3010, "R5 evicted", h);
    check(h == 1'b0, "R5 evicted block misses", {31'd0, h}, 32'd0);
  endtask

  task automatic t_write_hit();
    logic h;
    int r0;
    rd_chk(32'h0000_4008, "R7 fill", h);
    wr_chk(32'h0000_400C, 32'hDEAD_BEEF, "R7", h);
    check(h == 1'b1, "R7 write hit flag", {31'd0, h}, 32'd1);
    r0 = mem_rd_cnt;
    rd_chk(32'h0000_400C, "R7 updated word", h);
    check(h == 1'b1 && mem_rd_cnt == r0, "R7 new data from cache", mem_rd_cnt, r0);
  endtask

  task automatic t_write_miss();
    logic h;
    rd_chk(32'h0000_5000, "R8 resident", h);
    wr_chk(32'h0000_5004 + 2*CAP, 32'h1234_5678, "R8", h);
    check(h == 1'b0, "R8 write miss flag", {31'd0, h}, 32'd0);
    rd_chk(32'h0000_5000, "R8 set unchanged", h);
    check(h == 1'b1, "R8 resident still hits", {31'd0, h}, 32'd1);
    rd_chk(32'h0000_5004 + 2*CAP, "R8 no allocate", h);
    check(h == 1'b0, "R8 written address misses", {31'd0, h}, 32'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] rd;
    logic h;
    bit exp_h = ref_access(0, 32'h0000_6004);
    do_access(0, 32'h0000_6004, '0, 4, rd, h);
    check(rd == mem_word(32'h0000_6004) && h == exp_h, "R9 held response data",
          rd, mem_word(32'h0000_6004));
  endtask

  task automatic t_sequential();
    logic h;
    int hits = 0, exp_hits = 0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = 32'h0001_0000 + 32'(i * 4);
      if (ref_valid[int'(a[13:3])] && ref_tag[int'(a[13:3])] == a[31:14]) exp_hits++;
      rd_chk(a, "R10 sequential", h);
      if (h) hits++;
    end
    check(hits == exp_hits && hits == 32, "R10 sequential hit count", hits, exp_hits);
  endtask

  task automatic t_strided();
    logic h;
    int hits = 0, exp_hits = 0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = 32'h0002_0000 + 32'(i * 4);
      logic [31:0] b = 32'h0002_0000 + 32'(i * 512);
      if (ref_valid[int'(a[13:3])] && ref_tag[int'(a[13:3])] == a[31:14]) exp_hits++;
      rd_chk(a, "R10 strided A", h);
      if (h) hits++;
      if (ref_valid[int'(b[13:3])] && ref_tag[int'(b[13:3])] == b[31:14]) exp_hits++;
      rd_chk(b, "R10 strided B", h);
      if (h) hits++;
    end
    check(hits == exp_hits, "R10 strided hit count", hits, exp_hits);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSETS; s++) begin ref_valid[s] = 0; ref_tag[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss_and_split();
    t_read_hit();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_backpressure();
    t_sequential();
    t_strided();
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule